// File: doc/BRIEF.md
# PCI Interrupt Router

This block turns a PCI interrupt request into a numbered interrupt and drives the one interrupt line that goes to the CPU interrupt controller. Each request carries the requester's combined device/function number and its interrupt pin (0 to 3). The block takes the slot from the upper bits of the device/function number and turns slot and pin into an interrupt number. The result is an internal index, counted from a base of 32.

Two 32-bit configuration words, indexed by that internal index, decide how the CPU line responds. In the trigger word, a 1 means the line is pulse-triggered. For such a line, the CPU output goes high for exactly one cycle. Otherwise the line is level-triggered, and the CPU output takes the value of the polarity word bit at the same index. Requests arrive one per cycle on a strobe. Each request is acted on in the order it arrives, and both outputs are registered.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is active, and right after it is released, `cpuIrq` is 0 and `irqNum` is 0.
- R2: The slot is `devFunc[7:3]`; `devFunc[2:0]` has no effect. Slot 5 maps to 32 + pin, so its four pins rotate over numbers 32 to 35.
- R3: Slot 6 maps to 36 and slot 7 maps to 37, whatever the pin.
- R4: Slots 8 through 12 map to 38 + (slot − 8) + pin, which gives the range 38 to 45.
- R5: Every other slot maps to the pin value itself (0 to 3).
- R6: `irqNum` takes the mapped number on the clock edge that samples `intStb` high. It holds its value while `intStb` is low.
- R7: If the mapped number minus 32 lies in 0..31 and that bit of `edgeMask` is 1, `cpuIrq` is 1 for exactly one cycle after the strobe. It then returns to 0 unless a new request drives it.
- R8: If that bit of `edgeMask` is 0, `cpuIrq` takes that bit of `polMask` after the strobe. It holds that value until a later request changes it.
- R9: A request whose mapped number is below 32 has no in-range index. It leaves `cpuIrq` unchanged, except that a pulse already in progress still ends.
- R10: A request that arrives in the cycle a pulse is high sets the next value of `cpuIrq` itself. A second pulse request keeps the line high for one more cycle, and a level request sets the line to its polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| devFunc | input | 8 | Device/function number of the requester (slot in bits 7:3) |
| intPin | input | 2 | Interrupt pin index, 0 to 3 |
| intStb | input | 1 | Request strobe, one request per cycle |
| edgeMask | input | 32 | Per-index trigger select, 1 = one-cycle pulse |
| polMask | input | 32 | Per-index level value for level-triggered lines |
| irqNum | output | 8 | Registered mapped interrupt number of the last request |
| cpuIrq | output | 1 | Interrupt line to the CPU controller |

## Verification
Ending a pulse and acting on a new request can both fall due in the same cycle. The bench provokes this by presenting strobes on consecutive cycles: a pulse request, then another pulse request, then a level request with polarity 1. It expects the line to stay high through all three cycles and not drop after the first. It also places an out-of-range request in the cycle right after a pulse. There it expects the line to fall, because the pulse ends even though the request itself must not touch the line.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic loadNum;    // capture the mapped number
    logic driveHigh;  // set the CPU line
    logic driveLow;   // clear the CPU line
  } irqCtrlStb_t;

  typedef enum logic {
    LINE_IDLE  = 1'b0,
    LINE_PULSE = 1'b1
  } lineState_t;

endpackage

// File: rtl/pci_irq_slot_map.sv
module pci_irq_slot_map #(
  parameter int DEVFN_W   = 8,
  parameter int FUNC_W    = 3,
  parameter int PIN_W     = 2,
  parameter int NUM_W     = 8,
  parameter int IRQ_BASE  = 32,
  parameter int ROT_SLOT  = 5,
  parameter int FIX_SLOT_A = 6,
  parameter int FIX_LINE_A = 4,
  parameter int FIX_SLOT_B = 7,
  parameter int FIX_LINE_B = 5,
  parameter int EXP_FIRST = 8,
  parameter int EXP_LAST  = 12,
  parameter int EXP_LINE  = 6
) (
  input  logic [DEVFN_W-1:0] devFunc,
  input  logic [PIN_W-1:0]   intPin,
  output logic [NUM_W-1:0]   mappedNum
);

  localparam int SLOT_W = DEVFN_W - FUNC_W;

  logic [SLOT_W-1:0] slot;
  logic              unusedFunc;
  logic [NUM_W-1:0]  pinExt;
  logic [NUM_W-1:0]  rotPin;

  assign slot       = devFunc[DEVFN_W-1:FUNC_W];
  assign unusedFunc = ^devFunc[FUNC_W-1:0];
  assign pinExt     = NUM_W'(intPin);
  assign rotPin     = NUM_W'(intPin[1:0]);   // pin modulo four

  always_comb begin
    mappedNum = pinExt;  // unknown slots pass through
    if (slot == SLOT_W'(ROT_SLOT)) begin
      mappedNum = NUM_W'(IRQ_BASE) + rotPin;
    end else if (slot == SLOT_W'(FIX_SLOT_A)) begin
      mappedNum = NUM_W'(IRQ_BASE + FIX_LINE_A);
    end else if (slot == SLOT_W'(FIX_SLOT_B)) begin
      mappedNum = NUM_W'(IRQ_BASE + FIX_LINE_B);
    end else if ((slot >= SLOT_W'(EXP_FIRST)) && (slot <= SLOT_W'(EXP_LAST))) begin
      mappedNum = NUM_W'(IRQ_BASE + EXP_LINE) + NUM_W'(slot)
                - NUM_W'(EXP_FIRST) + pinExt;
    end
  end

endmodule

// File: rtl/pci_irq_router_dp.sv
module pci_irq_router_dp
  import pci_irq_router_pkg::*;
#(
  parameter int DEVFN_W  = 8,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int CFG_W    = 32,
  parameter int IRQ_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEVFN_W-1:0] devFunc,
  input  logic [PIN_W-1:0]   intPin,
  input  logic [CFG_W-1:0]   edgeMask,
  input  logic [CFG_W-1:0]   polMask,
  input  irqCtrlStb_t        stb,
  output logic               inRange,
  output logic               edgeBit,
  output logic               polBit,
  output logic [NUM_W-1:0]   irqNum,
  output logic               cpuIrq
);

  localparam int IDX_W = $clog2(CFG_W);

  logic [NUM_W-1:0] mappedNum;
  logic [NUM_W-1:0] idxFull;
  logic [IDX_W-1:0] idx;

  pci_irq_slot_map #(
    .DEVFN_W (DEVFN_W),
    .PIN_W   (PIN_W),
    .NUM_W   (NUM_W),
    .IRQ_BASE(IRQ_BASE)
  ) u_map (
    .devFunc  (devFunc),
    .intPin   (intPin),
    .mappedNum(mappedNum)
  );

  // Internal index relative to the base, with a range check on both sides
  assign idxFull = mappedNum - NUM_W'(IRQ_BASE);
  assign idx     = idxFull[IDX_W-1:0];
  assign inRange = (mappedNum >= NUM_W'(IRQ_BASE)) && (idxFull < NUM_W'(CFG_W));
  assign edgeBit = inRange & edgeMask[idx];
  assign polBit  = inRange & polMask[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqNum <= '0;
      cpuIrq <= 1'b0;
    end else begin
      if (stb.loadNum) irqNum <= mappedNum;
      if (stb.driveHigh)     cpuIrq <= 1'b1;
      else if (stb.driveLow) cpuIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_irq_router_ctrl.sv
module pci_irq_router_ctrl
  import pci_irq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        intStb,
  input  logic        inRange,
  input  logic        edgeBit,
  input  logic        polBit,
  output irqCtrlStb_t stb,
  output logic        pulseActive
);

  lineState_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = LINE_IDLE;
    stb.loadNum = intStb;
    if (intStb && inRange) begin
      if (edgeBit) begin
        stb.driveHigh = 1'b1;
        stateNxt      = LINE_PULSE;
      end else if (polBit) begin
        stb.driveHigh = 1'b1;
      end else begin
        stb.driveLow = 1'b1;
      end
    end else if (state == LINE_PULSE) begin
      stb.driveLow = 1'b1;   // pulse ends even under an ignored request
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LINE_IDLE;
    else        state <= stateNxt;
  end

  assign pulseActive = (state == LINE_PULSE);

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int DEVFN_W  = 8,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int CFG_W    = 32,
  parameter int IRQ_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEVFN_W-1:0] devFunc,
  input  logic [PIN_W-1:0]   intPin,
  input  logic               intStb,
  input  logic [CFG_W-1:0]   edgeMask,
  input  logic [CFG_W-1:0]   polMask,
  output logic [NUM_W-1:0]   irqNum,
  output logic               cpuIrq
);

  irqCtrlStb_t stb;
  logic        inRange;
  logic        edgeBit;
  logic        polBit;
  logic        pulseActive;

  pci_irq_router_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .intStb     (intStb),
    .inRange    (inRange),
    .edgeBit    (edgeBit),
    .polBit     (polBit),
    .stb        (stb),
    .pulseActive(pulseActive)
  );

  pci_irq_router_dp #(
    .DEVFN_W (DEVFN_W),
    .PIN_W   (PIN_W),
    .NUM_W   (NUM_W),
    .CFG_W   (CFG_W),
    .IRQ_BASE(IRQ_BASE)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .devFunc (devFunc),
    .intPin  (intPin),
    .edgeMask(edgeMask),
    .polMask (polMask),
    .stb     (stb),
    .inRange (inRange),
    .edgeBit (edgeBit),
    .polBit  (polBit),
    .irqNum  (irqNum),
    .cpuIrq  (cpuIrq)
  );

endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int NUM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             intStb,
  input logic             inRange,
  input logic             edgeBit,
  input logic             polBit,
  input logic             pulseActive,
  input logic             driveHigh,
  input logic             driveLow,
  input logic [NUM_W-1:0] irqNum,
  input logic             cpuIrq
);

  // R6: number register holds without a request
  a_r6_num_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !intStb |=> $stable(irqNum));

  // R7: pulse request raises the line and enters the pulse state
  a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (intStb && inRange && edgeBit) |=> (cpuIrq && pulseActive));

  // R7: a pulse with no new request is followed by a low line
  a_r7_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseActive && !intStb) |=> !cpuIrq);

  // R8: level request copies its polarity
  a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (intStb && inRange && !edgeBit) |=> (cpuIrq == $past(polBit)));

  // R9: an out-of-range request outside a pulse leaves the line alone
  a_r9_oor_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!(intStb && inRange) && !pulseActive) |=> $stable(cpuIrq));

  // R10: control never asks for both drive directions
  a_r10_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({driveHigh, driveLow}));

endmodule

bind pci_irq_router pci_irq_router_chk #(.NUM_W(NUM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .intStb     (intStb),
  .inRange    (inRange),
  .edgeBit    (edgeBit),
  .polBit     (polBit),
  .pulseActive(pulseActive),
  .driveHigh  (stb.driveHigh),
  .driveLow   (stb.driveLow),
  .irqNum     (irqNum),
  .cpuIrq     (cpuIrq)
);

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/1ps
module pci_irq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  devFunc = '0;
  logic [1:0]  intPin = '0;
  logic        intStb = 1'b0;
  logic [31:0] edgeMask = '0;
  logic [31:0] polMask = '0;
  logic [7:0]  irqNum;
  logic        cpuIrq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  pci_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .devFunc(devFunc), .intPin(intPin),
    .intStb(intStb), .edgeMask(edgeMask), .polMask(polMask),
    .irqNum(irqNum), .cpuIrq(cpuIrq)
  );

  localparam logic [31:0] POL_PAT = 32'hA5A5_5A5A;
  localparam int NVEC = 14;
  // {devFunc, pin, expected number}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h28, 2'd0, 8'd32}, {8'h29, 2'd1, 8'd33}, {8'h2F, 2'd3, 8'd35},
    {8'h30, 2'd2, 8'd36}, {8'h3A, 2'd0, 8'd37}, {8'h40, 2'd0, 8'd38},
    {8'h48, 2'd1, 8'd40}, {8'h50, 2'd2, 8'd42}, {8'h58, 2'd3, 8'd44},
    {8'h60, 2'd3, 8'd45}, {8'h68, 2'd2, 8'd2},  {8'h00, 2'd1, 8'd1},
    {8'hF8, 2'd3, 8'd3},  {8'h20, 2'd0, 8'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive a request now (at a falling edge) and return at the next falling edge
  task automatic present(input logic [7:0] df, input logic [1:0] p);
    devFunc = df; intPin = p; intStb = 1'b1;
    @(negedge clk);
    intStb = 1'b0;
  endtask

  task automatic idle();
    intStb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic       expLine;
    logic [7:0] expNum;
    string      tag;
    repeat (3) @(negedge clk);
    check("R1 line in reset", cpuIrq, 0);
    check("R1 num in reset", irqNum, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 line after reset", cpuIrq, 0);

    // Table walk: level mode only, varied polarity
    polMask = POL_PAT; edgeMask = '0;
    expLine = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      present(VEC[i][17:10], VEC[i][9:8]);
      expNum = VEC[i][7:0];
      case (VEC[i][17:13])
        5'd5:                            tag = "R2 rotating slot";
        5'd6, 5'd7:                      tag = "R3 fixed slot";
        5'd8, 5'd9, 5'd10, 5'd11, 5'd12: tag = "R4 expansion slot";
        default:                         tag = "R5 pass-through";
      endcase
      check(tag, irqNum, expNum);
      if (expNum >= 8'd32) begin
        expLine = POL_PAT[expNum - 8'd32];
        check("R8 level follows polarity", cpuIrq, expLine);
      end else begin
        check("R9 out of range keeps line", cpuIrq, expLine);
      end
      idle();
    end

    // R7: single pulse on slot 6 (index 4)
    edgeMask = 32'h0000_0010; polMask = 32'h0000_0001;
    present(8'h31, 2'd0);
    check("R7 pulse high", cpuIrq, 1);
    check("R3 number during pulse", irqNum, 36);
    idle();
    check("R7 pulse back low", cpuIrq, 0);
    idle();
    check("R7 stays low", cpuIrq, 0);

    // R10: pulse, pulse again, then level-high request on back-to-back cycles
    present(8'h30, 2'd0);
    check("R10 first pulse", cpuIrq, 1);
    present(8'h30, 2'd1);
    check("R10 second pulse keeps line", cpuIrq, 1);
    present(8'h28, 2'd0);
    check("R10 level after pulse", cpuIrq, 1);
    idle();
    check("R8 level holds", cpuIrq, 1);

    // R9: out-of-range while level is high
    present(8'h00, 2'd2);
    check("R9 line kept high", cpuIrq, 1);
    check("R5 number for slot 0", irqNum, 2);
    idle();

    // R8: level low lowers the line
    present(8'h29, 2'd1);
    check("R8 level low", cpuIrq, 0);
    idle();

    // R9: out-of-range right after pulse still ends the pulse
    present(8'h30, 2'd3);
    check("R9 pulse started", cpuIrq, 1);
    present(8'h18, 2'd3);
    check("R9 pulse ends under ignored request", cpuIrq, 0);
    check("R5 number for slot 3", irqNum, 3);

    // R6: number holds without strobes
    devFunc = 8'h28; intPin = 2'd1;
    idle(); idle(); idle();
    check("R6 number holds", irqNum, 3);

    // R1: reset in mid-run clears a high level line
    present(8'h28, 2'd0);
    check("R8 level high before reset", cpuIrq, 1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset line", cpuIrq, 0);
    check("R1 async reset num", irqNum, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule